// File: doc/BRIEF.md
# Accumulator Processor Fetch-Execute Sequencer

This block is the control core of a very small 8-bit accumulator machine that addresses a 16-bit memory space through a byte-wide synchronous read port. When reset is released it reads a two-byte start address from a fixed boot location near the top of memory and places it in the program counter. It then loops without end: it reads an opcode, reads the opcode's operand bytes, and spends one further cycle writing the result into the architectural registers.

Four opcodes are understood: load accumulator with an immediate byte, add an immediate byte to the accumulator, load the 16-bit stack pointer with an immediate word, and jump to an absolute 16-bit address. Any other opcode stops the core for good and raises an error output. The accumulator, stack pointer, program counter and the carry, zero and negative flags are brought out as ports for observation.

Each memory read takes one cycle to return. The core presents an address with a read strobe in one cycle and uses the data on the following cycle, so no two reads are ever back to back.

Top module: `acc_core`

## Requirements
- R1: After reset is released, the first two reads are at 0xFFFE and then 0xFFFF. The byte from 0xFFFE is the upper half of the start address and the byte from 0xFFFF is the lower half. The next read, the first opcode fetch, is at that start address (a vector of 0x80, 0x00 starts execution at 0x8000).
- R2: While rstN is low, memRd is 0, and accOut, spOut, pcOut, the three flags and illegalOp are all 0.
- R3: A read presents memAddr with memRd high for exactly one cycle, and the data is taken from memData on the next cycle. A read cycle is never followed directly by another read cycle. Every program read is at pcOut, and pcOut has advanced by one in the cycle after it.
- R4: Opcode 0x86 loads accOut with the byte that follows the opcode. The flags are left unchanged.
- R5: Opcode 0x8B adds the following byte to accOut modulo 256. It sets flagC to the carry out of bit 7, flagZ when the result is 0, and flagN to bit 7 of the result. For example, 0xFE + 0x01 gives 0xFF with C=0, Z=0, N=1.
- R6: Opcode 0x8E takes two operand bytes, upper byte first, and loads them into spOut.
- R7: Opcode 0x7E takes two operand bytes, upper byte first, and continues execution at that address. A jump whose target is its own address repeats forever.
- R8: After an instruction completes, the next opcode is read from the address directly after its last operand byte.
- R9: An opcode other than 0x86, 0x8B, 0x8E or 0x7E sets illegalOp. After that the core makes no further reads and all registers hold their values. illegalOp stays at 1 until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| memAddr | output | 16 | Read address |
| memRd | output | 1 | Read strobe; data is returned one cycle later |
| memData | input | 8 | Read data from memory |
| accOut | output | 8 | Accumulator |
| spOut | output | 16 | Stack pointer |
| pcOut | output | 16 | Program counter |
| flagC | output | 1 | Carry flag |
| flagZ | output | 1 | Zero flag |
| flagN | output | 1 | Negative flag |
| illegalOp | output | 1 | Sticky unknown-opcode indication |

## Verification
Two functions share a single cycle in this core. In the cycle where an instruction executes, its register write lands at the same edge as the fetch address for the next opcode, which comes from the program counter that was just advanced or loaded by a jump.

The bench provokes this by placing every instruction directly after the previous one, and by following arithmetic with an immediate jump. A scoreboard judges the result: for each read in sequence it expects a specific address together with the accumulator, stack pointer and flags that must already be visible when that read is issued. A late register write, or a fetch from the wrong address, is therefore caught at the very next read.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;

  localparam logic [7:0] OP_LDA_IMM = 8'h86;
  localparam logic [7:0] OP_ADD_IMM = 8'h8B;
  localparam logic [7:0] OP_LDS_IMM = 8'h8E;
  localparam logic [7:0] OP_JMP_ABS = 8'h7E;

  typedef enum logic [1:0] {
    SEL_PC     = 2'd0,
    SEL_VEC_HI = 2'd1,
    SEL_VEC_LO = 2'd2
  } addrSel_e;

  typedef struct packed {
    logic     memRd;
    addrSel_e addrSel;
    logic     pcInc;
    logic     capHi;
    logic     capLo;
    logic     loadPcVec;
    logic     ldAcc;
    logic     addAcc;
    logic     ldSp;
    logic     jump;
  } ctrlStrb_t;

endpackage

// File: rtl/acc_core_ctrl.sv
module acc_core_ctrl
  import acc_core_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] memData,
  output ctrlStrb_t         strb,
  output logic              illegalOp
);

  typedef enum logic [3:0] {
    S_BOOT, S_VHI, S_VHI_W, S_VLO, S_VLO_W,
    S_OP, S_DEC, S_B1, S_B1_W, S_B2, S_B2_W, S_EXEC, S_HALT
  } state_e;

  state_e            state, stateNxt;
  logic [DATA_W-1:0] opcode;

  function automatic logic isKnown(input logic [DATA_W-1:0] op);
    return (op == OP_LDA_IMM) || (op == OP_ADD_IMM) ||
           (op == OP_LDS_IMM) || (op == OP_JMP_ABS);
  endfunction

  function automatic logic isWide(input logic [DATA_W-1:0] op);
    return (op == OP_LDS_IMM) || (op == OP_JMP_ABS);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_BOOT;
      opcode    <= '0;
      illegalOp <= 1'b0;
    end else begin
      state <= stateNxt;
      if (state == S_DEC) begin
        opcode <= memData;
        if (!isKnown(memData)) illegalOp <= 1'b1;
      end
    end
  end

  always_comb begin
    strb     = '0;
    stateNxt = state;
    case (state)
      S_BOOT:  stateNxt = S_VHI;
      S_VHI: begin
        strb.memRd   = 1'b1;
        strb.addrSel = SEL_VEC_HI;
        stateNxt     = S_VHI_W;
      end
      S_VHI_W: begin
        strb.capHi = 1'b1;
        stateNxt   = S_VLO;
      end
      S_VLO: begin
        strb.memRd   = 1'b1;
        strb.addrSel = SEL_VEC_LO;
        stateNxt     = S_VLO_W;
      end
      S_VLO_W: begin
        strb.loadPcVec = 1'b1;
        stateNxt       = S_OP;
      end
      S_OP: begin
        strb.memRd = 1'b1;
        strb.pcInc = 1'b1;
        stateNxt   = S_DEC;
      end
      S_DEC:   stateNxt = isKnown(memData) ? S_B1 : S_HALT;
      S_B1: begin
        strb.memRd = 1'b1;
        strb.pcInc = 1'b1;
        stateNxt   = S_B1_W;
      end
      S_B1_W: begin
        strb.capHi = 1'b1;
        stateNxt   = isWide(opcode) ? S_B2 : S_EXEC;
      end
      S_B2: begin
        strb.memRd = 1'b1;
        strb.pcInc = 1'b1;
        stateNxt   = S_B2_W;
      end
      S_B2_W: begin
        strb.capLo = 1'b1;
        stateNxt   = S_EXEC;
      end
      S_EXEC: begin
        strb.ldAcc  = (opcode == OP_LDA_IMM);
        strb.addAcc = (opcode == OP_ADD_IMM);
        strb.ldSp   = (opcode == OP_LDS_IMM);
        strb.jump   = (opcode == OP_JMP_ABS);
        stateNxt    = S_OP;
      end
      S_HALT:  stateNxt = S_HALT;
      default: stateNxt = S_HALT;
    endcase
  end

endmodule

// File: rtl/acc_core_dpath.sv
module acc_core_dpath
  import acc_core_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2 * DATA_W,
  parameter logic [ADDR_W-1:0] RESET_VEC = 16'hFFFE
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [DATA_W-1:0] memData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] pcOut,
  output logic [DATA_W-1:0] accOut,
  output logic [ADDR_W-1:0] spOut,
  output logic              flagC,
  output logic              flagZ,
  output logic              flagN
);

  localparam logic [ADDR_W-1:0] ONE_A  = 1;
  localparam logic [ADDR_W-1:0] VEC_LO = RESET_VEC + ONE_A;

  logic [ADDR_W-1:0] pc, sp;
  logic [DATA_W-1:0] acc, opHi, opLo;
  logic              fC, fZ, fN;
  logic [DATA_W:0]   sumExt;

  assign sumExt = {1'b0, acc} + {1'b0, opHi};

  always_comb begin
    case (strb.addrSel)
      SEL_VEC_HI: memAddr = RESET_VEC;
      SEL_VEC_LO: memAddr = VEC_LO;
      default:    memAddr = pc;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc   <= '0;
      sp   <= '0;
      acc  <= '0;
      opHi <= '0;
      opLo <= '0;
      fC   <= 1'b0;
      fZ   <= 1'b0;
      fN   <= 1'b0;
    end else begin
      if (strb.loadPcVec)  pc <= {opHi, memData};
      else if (strb.jump)  pc <= {opHi, opLo};
      else if (strb.pcInc) pc <= pc + ONE_A;
      if (strb.capHi) opHi <= memData;
      if (strb.capLo) opLo <= memData;
      if (strb.ldAcc) acc <= opHi;
      if (strb.addAcc) begin
        acc <= sumExt[DATA_W-1:0];
        fC  <= sumExt[DATA_W];
        fZ  <= (sumExt[DATA_W-1:0] == '0);
        fN  <= sumExt[DATA_W-1];
      end
      if (strb.ldSp) sp <= {opHi, opLo};
    end
  end

  assign pcOut  = pc;
  assign spOut  = sp;
  assign accOut = acc;
  assign flagC  = fC;
  assign flagZ  = fZ;
  assign flagN  = fN;

endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_core_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2 * DATA_W,
  parameter logic [ADDR_W-1:0] RESET_VEC = 16'hFFFE
) (
  input  logic              clk,
  input  logic              rstN,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRd,
  input  logic [DATA_W-1:0] memData,
  output logic [DATA_W-1:0] accOut,
  output logic [ADDR_W-1:0] spOut,
  output logic [ADDR_W-1:0] pcOut,
  output logic              flagC,
  output logic              flagZ,
  output logic              flagN,
  output logic              illegalOp
);

  ctrlStrb_t strb;

  acc_core_ctrl #(.DATA_W(DATA_W)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .memData   (memData),
    .strb      (strb),
    .illegalOp (illegalOp)
  );

  acc_core_dpath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .RESET_VEC(RESET_VEC)) i_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .memData (memData),
    .memAddr (memAddr),
    .pcOut   (pcOut),
    .accOut  (accOut),
    .spOut   (spOut),
    .flagC   (flagC),
    .flagZ   (flagZ),
    .flagN   (flagN)
  );

  assign memRd = strb.memRd;

endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] RESET_VEC = 16'hFFFE
) (
  input logic              clk,
  input logic              rstN,
  input logic              memRd,
  input logic [ADDR_W-1:0] memAddr,
  input logic [ADDR_W-1:0] pcOut,
  input logic              illegalOp
);

  localparam logic [ADDR_W-1:0] ONE_A  = 1;
  localparam logic [ADDR_W-1:0] VEC_LO = RESET_VEC + ONE_A;

  logic progRd;
  assign progRd = memRd && (memAddr != RESET_VEC) && (memAddr != VEC_LO);

  // R1
  vec_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memRd && memAddr == VEC_LO) |-> ($past(memRd, 2) && $past(memAddr, 2) == RESET_VEC));

  // R3
  rd_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRd |=> !memRd);

  // R3
  prog_rd_pc_chk: assert property (@(posedge clk) disable iff (!rstN)
    progRd |-> (memAddr == pcOut));

  // R3
  pc_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    progRd |=> (pcOut == $past(pcOut) + ONE_A));

  // R9
  halt_no_rd_chk: assert property (@(posedge clk) disable iff (!rstN)
    illegalOp |-> !memRd);

  // R9
  illegal_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(illegalOp) |-> illegalOp);

endmodule

bind acc_core acc_core_chk #(.ADDR_W(ADDR_W), .RESET_VEC(RESET_VEC)) i_chk (.*);

// File: tb/test_acc_core.sv
`timescale 1ns/1ps
module test_acc_core;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] memAddr;
  logic        memRd;
  logic [7:0]  memData = 8'h00;
  logic [7:0]  accOut;
  logic [15:0] spOut, pcOut;
  logic        flagC, flagZ, flagN, illegalOp;

  acc_core i_acc_core (
    .clk(clk), .rstN(rstN), .memAddr(memAddr), .memRd(memRd), .memData(memData),
    .accOut(accOut), .spOut(spOut), .pcOut(pcOut),
    .flagC(flagC), .flagZ(flagZ), .flagN(flagN), .illegalOp(illegalOp)
  );

  always #2.5 clk = ~clk;

  // memory model: one cycle read latency
  logic [7:0] mem [int];
  function automatic logic [7:0] rdMem(input logic [15:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : 8'h00;
  endfunction
  always @(posedge clk) if (memRd) memData <= rdMem(memAddr);

  typedef struct packed {
    logic [15:0] addr;
    logic [7:0]  acc;
    logic [15:0] sp;
    logic [2:0]  czn;
  } expItem_t;

  expItem_t expQ[$];
  string    tagQ[$];
  int       total = 0;
  int       bad = 0;
  logic     monEn = 1'b0;
  int       cyc = 0;

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic expRd(input logic [15:0] a, input logic [7:0] acc, input logic [15:0] sp,
                       input logic [2:0] czn, input string tag);
    expItem_t it;
    it.addr = a; it.acc = acc; it.sp = sp; it.czn = czn;
    expQ.push_back(it);
    tagQ.push_back(tag);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (monEn && memRd) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R9 unexpected read", {16'h0, memAddr}, 32'h0);
      end else begin
        expItem_t e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        chk(memAddr == e.addr, {t, " addr"}, {16'h0, memAddr}, {16'h0, e.addr});
        chk(accOut == e.acc, {t, " acc"}, {24'h0, accOut}, {24'h0, e.acc});
        chk(spOut == e.sp, {t, " sp"}, {16'h0, spOut}, {16'h0, e.sp});
        chk({flagC, flagZ, flagN} == e.czn, {t, " flags"}, {29'h0, flagC, flagZ, flagN}, {29'h0, e.czn});
      end
    end
  end

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      bad++; total++;
      $display("FAIL R7 watchdog actual=timeout expected=finished");
      finishRun();
    end
  end

  task automatic chkReset(input string tag);
    chk(memRd == 1'b0, {tag, " memRd"}, {31'h0, memRd}, 32'h0);
    chk(accOut == 8'h00 && spOut == 16'h0 && pcOut == 16'h0, {tag, " regs"},
        {accOut, spOut[7:0], pcOut[15:0]}, 32'h0);
    chk({flagC, flagZ, flagN, illegalOp} == 4'b0, {tag, " flags"},
        {28'h0, flagC, flagZ, flagN, illegalOp}, 32'h0);
  endtask

  localparam logic [2:0] F0 = 3'b000, FN = 3'b001, FCZ = 3'b110;

  initial begin
    // program 1
    mem[16'hFFFE] = 8'h80; mem[16'hFFFF] = 8'h00;
    mem[16'h8000] = 8'h8E; mem[16'h8001] = 8'h01; mem[16'h8002] = 8'hFF;
    mem[16'h8003] = 8'h86; mem[16'h8004] = 8'hFE;
    mem[16'h8005] = 8'h8B; mem[16'h8006] = 8'h01;
    mem[16'h8007] = 8'h8B; mem[16'h8008] = 8'h01;
    mem[16'h8009] = 8'h86; mem[16'h800A] = 8'h7F;
    mem[16'h800B] = 8'h8B; mem[16'h800C] = 8'h80;
    mem[16'h800D] = 8'h7E; mem[16'h800E] = 8'h80; mem[16'h800F] = 8'h20;
    mem[16'h8020] = 8'h8B; mem[16'h8021] = 8'h01;
    mem[16'h8022] = 8'h7E; mem[16'h8023] = 8'h80; mem[16'h8024] = 8'h22;

    repeat (3) @(negedge clk);
    chkReset("R2 reset");

    expRd(16'hFFFE, 8'h00, 16'h0000, F0, "R1 vector hi");
    expRd(16'hFFFF, 8'h00, 16'h0000, F0, "R1 vector lo");
    expRd(16'h8000, 8'h00, 16'h0000, F0, "R1 start");
    expRd(16'h8001, 8'h00, 16'h0000, F0, "R3 operand");
    expRd(16'h8002, 8'h00, 16'h0000, F0, "R3 operand");
    expRd(16'h8003, 8'h00, 16'h01FF, F0, "R6 sp load");
    expRd(16'h8004, 8'h00, 16'h01FF, F0, "R3 operand");
    expRd(16'h8005, 8'hFE, 16'h01FF, F0, "R4 acc load");
    expRd(16'h8006, 8'hFE, 16'h01FF, F0, "R3 operand");
    expRd(16'h8007, 8'hFF, 16'h01FF, FN, "R5 add negative");
    expRd(16'h8008, 8'hFF, 16'h01FF, FN, "R8 next");
    expRd(16'h8009, 8'h00, 16'h01FF, FCZ, "R5 add wrap");
    expRd(16'h800A, 8'h00, 16'h01FF, FCZ, "R8 next");
    expRd(16'h800B, 8'h7F, 16'h01FF, FCZ, "R4 flags kept");
    expRd(16'h800C, 8'h7F, 16'h01FF, FCZ, "R8 next");
    expRd(16'h800D, 8'hFF, 16'h01FF, FN, "R5 add clears C Z");
    expRd(16'h800E, 8'hFF, 16'h01FF, FN, "R3 operand");
    expRd(16'h800F, 8'hFF, 16'h01FF, FN, "R3 operand");
    expRd(16'h8020, 8'hFF, 16'h01FF, FN, "R7 jump target");
    expRd(16'h8021, 8'hFF, 16'h01FF, FN, "R8 next");
    for (int k = 0; k < 3; k++) begin
      expRd(16'h8022, 8'h00, 16'h01FF, FCZ, "R7 self loop");
      expRd(16'h8023, 8'h00, 16'h01FF, FCZ, "R7 self loop");
      expRd(16'h8024, 8'h00, 16'h01FF, FCZ, "R7 self loop");
    end

    rstN = 1'b1;
    monEn = 1'b1;
    wait (expQ.size() == 0);
    monEn = 1'b0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      chk(pcOut >= 16'h8022 && pcOut <= 16'h8025 && illegalOp == 1'b0, "R7 stays in loop",
          {16'h0, pcOut}, 32'h8022);
    end

    // program 2: illegal opcode
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    chkReset("R2 second reset");
    mem[16'hFFFE] = 8'h90; mem[16'hFFFF] = 8'h00;
    mem[16'h9000] = 8'h86; mem[16'h9001] = 8'h55;
    mem[16'h9002] = 8'h01;
    expRd(16'hFFFE, 8'h00, 16'h0000, F0, "R1 vector hi");
    expRd(16'hFFFF, 8'h00, 16'h0000, F0, "R1 vector lo");
    expRd(16'h9000, 8'h00, 16'h0000, F0, "R1 start 9000");
    expRd(16'h9001, 8'h00, 16'h0000, F0, "R3 operand");
    expRd(16'h9002, 8'h55, 16'h0000, F0, "R4 acc load");
    rstN = 1'b1;
    monEn = 1'b1;
    wait (expQ.size() == 0);
    repeat (25) @(negedge clk);
    chk(illegalOp == 1'b1, "R9 illegal set", {31'h0, illegalOp}, 32'h1);
    chk(accOut == 8'h55 && pcOut == 16'h9003, "R9 regs held", {8'h0, accOut, pcOut}, 32'h00559003);
    monEn = 1'b0;
    rstN = 1'b0;
    @(negedge clk);
    chk(illegalOp == 1'b0, "R9 cleared by reset", {31'h0, illegalOp}, 32'h0);
    chkReset("R2 third reset");
    finishRun();
  end

endmodule